// File: doc/BRIEF.md
# PLL Power-State and Clock-Switch Controller

This block is the control logic that sits beside an on-chip frequency-multiplier PLL. Software writes one control word at a time. The word holds a PLL run bit, a PLL standby bit, three divider-select fields (a bus-clock divider, a core-clock divider and a peripheral-clock divider), a clock-pin drive enable and a settling start value. From these bits the block steps the PLL through its three power states: off, standby and on. It also decides which divider fields the write is allowed to change during that step.

When a write brings the PLL up into the on state, the new divider selection is not applied at once. A settling counter is loaded with the start value and counts up. The divider selection is committed only when the counter wraps. Writes that arrive during that window are refused. Every commit is announced by a one-cycle strobe, and the strobe carries all three divider values together. The block also reports whether the chip may enter its low-power standby mode. The analog loop, the dividers themselves and the glitch-free clock switch all live outside this block. It drives only their select and enable controls.

Top module: `pll_pwr_ctrl`

## Requirements
- R1: After reset, `pwr_state` is 0 (off), `ckout_en` is 1, `busy`, `commit_stb` and `field_err` are 0, and `commit_stc`/`commit_ifc`/`commit_pfc` equal their reset parameters (defaults 0, 1 and 2).
- R2: The state codes are off=0, standby=1 and on=2. An accepted write moves the state to standby when it has run=0 and standby=1, and to off when both bits are 0. From standby, a write with run=1 moves to on. From on, a write with run=0 leaves on.
- R3: From off, a write with run=1 and standby=1 goes straight to on. From on, a write with both bits 0 goes straight to off. From off, a write with run=1 and standby=0 leaves the state at off.
- R4: A write that moves between off and standby may change only the bus-clock field. A write that moves between standby and on may change only the core and peripheral fields. A write that moves directly between off and on, or that keeps the state, may change all three fields. If a write gives a new value for a field it may not change, that field keeps its old value.
- R5: `field_err` goes to 1 in the cycle after a write that tried to change a field it was not allowed to change. It then stays at 1 until reset.
- R6: A write that enters the on state from off or standby raises `busy` in the next cycle. `busy` stays high for 2^CNT_W − S cycles, where S is `wr_settle_start`. In the first cycle that `busy` is low again, `commit_stb` is high for exactly one cycle and the commit outputs show the newly accepted field values.
- R7: An accepted write that does not enter the on state produces `commit_stb` in the second cycle after the write is sampled, together with the accepted field values. The strobe lasts one cycle.
- R8: `ckout_en` takes the written clock-pin enable in the cycle after any accepted write. This also holds for a write that starts the settling counter, where the new value appears while `busy` is still high.
- R9: A write sampled while `busy` is 1 is ignored. `pwr_state`, `ckout_en` and the pending field values are left unchanged.
- R10: `stby_ok` is 0 when `clk_mode` is 3 or 4 and `pwr_state` is not off. In every other case it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_mode | input | 3 | Strap-selected clock mode |
| wr_en | input | 1 | Write strobe for the control word |
| wr_pll_en | input | 1 | PLL run bit |
| wr_pll_stby | input | 1 | PLL standby bit |
| wr_stc | input | STC_W | Bus-clock divider select |
| wr_ifc | input | IFC_W | Core-clock divider select |
| wr_pfc | input | PFC_W | Peripheral-clock divider select |
| wr_ckout_en | input | 1 | Clock-pin drive enable |
| wr_settle_start | input | CNT_W | Settling counter start value |
| pwr_state | output | 2 | Current PLL power state |
| ckout_en | output | 1 | Clock-pin drive enable control |
| stby_ok | output | 1 | Low-power standby allowed |
| busy | output | 1 | Settling window active |
| commit_stb | output | 1 | One-cycle commit strobe |
| commit_stc | output | STC_W | Committed bus-clock divider select |
| commit_ifc | output | IFC_W | Committed core-clock divider select |
| commit_pfc | output | PFC_W | Committed peripheral-clock divider select |
| field_err | output | 1 | Sticky disallowed-field flag |

## Verification
The bench builds the block with its default parameters: 3-bit divider fields and an 8-bit settling counter. With those sizes the whole settling range is short, so one directed write can use a start value of 0 and run the full 256-cycle window. Inside that window a refused write is injected. The random writes use start values near the top of the range, including 255, which gives a one-cycle window. These keep the run short and still exercise every power-state pairing in all three mode classes.

// File: rtl/pll_ctrl_pkg.sv
package pll_ctrl_pkg;

  typedef enum logic [1:0] {
    PWR_OFF  = 2'd0,
    PWR_STBY = 2'd1,
    PWR_ON   = 2'd2
  } pwr_state_e;

  // field permission mask bits: [0] bus clock, [1] core clock, [2] peripheral clock
  localparam logic [2:0] FLD_STC = 3'b001;
  localparam logic [2:0] FLD_IFC = 3'b010;
  localparam logic [2:0] FLD_PFC = 3'b100;
  localparam logic [2:0] FLD_ALL = 3'b111;

endpackage

// File: rtl/pll_state_fsm.sv
module pll_state_fsm
  import pll_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_acc,
  input  logic       wr_pll_en,
  input  logic       wr_pll_stby,
  output pwr_state_e state_q,
  output logic [2:0] fld_allow,
  output logic       enter_on
);

  pwr_state_e tgt;
  pwr_state_e state_d;

  always_comb begin
    if (wr_pll_en) begin
      tgt = (state_q == PWR_OFF && !wr_pll_stby) ? PWR_OFF : PWR_ON;
    end else begin
      tgt = wr_pll_stby ? PWR_STBY : PWR_OFF;
    end

    if (tgt == state_q) begin
      fld_allow = FLD_ALL;
    end else if (tgt != PWR_ON && state_q != PWR_ON) begin
      fld_allow = FLD_STC;
    end else if (tgt == PWR_OFF || state_q == PWR_OFF) begin
      fld_allow = FLD_ALL;
    end else begin
      fld_allow = FLD_IFC | FLD_PFC;
    end

    enter_on = wr_acc && (tgt == PWR_ON) && (state_q != PWR_ON);
    state_d  = wr_acc ? tgt : state_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PWR_OFF;
    else        state_q <= state_d;
  end

  // R3
  off_on_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == PWR_OFF && state_q == PWR_ON) |-> $past(wr_pll_stby) && $past(wr_pll_en));

  // R2
  no_change_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_acc |=> $stable(state_q));

endmodule

// File: rtl/pll_settle_cnt.sv
module pll_settle_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] start_val,
  output logic             busy,
  output logic             overflow
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;

  always_comb begin
    overflow = busy_q && (cnt_q == CNT_MAX);
    cnt_d    = cnt_q;
    busy_d   = busy_q;
    if (start) begin
      cnt_d  = start_val;
      busy_d = 1'b1;
    end else if (overflow) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;

  // R6
  settle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !overflow) |=> busy_q && (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/pll_div_field.sv
module pll_div_field #(
  parameter int           W   = 3,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_acc,
  input  logic         allow,
  input  logic [W-1:0] wr_val,
  input  logic         commit_go,
  output logic [W-1:0] commit_val,
  output logic         viol
);

  logic [W-1:0] stage_q, stage_d;
  logic [W-1:0] commit_q, commit_d;
  logic         stage_en;

  always_comb begin
    stage_en = wr_acc && allow;
    stage_d  = stage_en ? wr_val : stage_q;
    commit_d = commit_go ? stage_q : commit_q;
    viol     = wr_acc && !allow && (wr_val != stage_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= RST;
      commit_q <= RST;
    end else begin
      stage_q  <= stage_d;
      commit_q <= commit_d;
    end
  end

  assign commit_val = commit_q;

  // R4
  blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && !allow) |=> $stable(stage_q));

  // R7
  commit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_go |=> $stable(commit_q));

endmodule

// File: rtl/pll_pwr_ctrl.sv
module pll_pwr_ctrl
  import pll_ctrl_pkg::*;
#(
  parameter int               STC_W   = 3,
  parameter int               IFC_W   = 3,
  parameter int               PFC_W   = 3,
  parameter int               CNT_W   = 8,
  parameter logic [STC_W-1:0] STC_RST = 3'd0,
  parameter logic [IFC_W-1:0] IFC_RST = 3'd1,
  parameter logic [PFC_W-1:0] PFC_RST = 3'd2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       clk_mode,
  input  logic             wr_en,
  input  logic             wr_pll_en,
  input  logic             wr_pll_stby,
  input  logic [STC_W-1:0] wr_stc,
  input  logic [IFC_W-1:0] wr_ifc,
  input  logic [PFC_W-1:0] wr_pfc,
  input  logic             wr_ckout_en,
  input  logic [CNT_W-1:0] wr_settle_start,
  output logic [1:0]       pwr_state,
  output logic             ckout_en,
  output logic             stby_ok,
  output logic             busy,
  output logic             commit_stb,
  output logic [STC_W-1:0] commit_stc,
  output logic [IFC_W-1:0] commit_ifc,
  output logic [PFC_W-1:0] commit_pfc,
  output logic             field_err
);

  localparam logic [2:0] MODE_LOCK_A = 3'd3;
  localparam logic [2:0] MODE_LOCK_B = 3'd4;

  // reset: asserted at once, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  pwr_state_e state_q;
  logic [2:0] fld_allow;
  logic       enter_on;
  logic       wr_acc;
  logic       overflow;
  logic [2:0] viol;

  assign wr_acc = wr_en && !busy;

  pll_state_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_s),
    .wr_acc      (wr_acc),
    .wr_pll_en   (wr_pll_en),
    .wr_pll_stby (wr_pll_stby),
    .state_q     (state_q),
    .fld_allow   (fld_allow),
    .enter_on    (enter_on)
  );

  pll_settle_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_s),
    .start     (enter_on),
    .start_val (wr_settle_start),
    .busy      (busy),
    .overflow  (overflow)
  );

  // commit sequencing, clock-pin enable and error flag
  logic imm_q, imm_d;
  logic stb_q, stb_d;
  logic ck_q, ck_d;
  logic err_q, err_d;
  logic commit_go;

  always_comb begin
    commit_go = imm_q || overflow;
    imm_d     = wr_acc && !enter_on;
    stb_d     = commit_go;
    ck_d      = wr_acc ? wr_ckout_en : ck_q;
    err_d     = err_q || (|viol);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      imm_q <= 1'b0;
      stb_q <= 1'b0;
      ck_q  <= 1'b1;
      err_q <= 1'b0;
    end else begin
      imm_q <= imm_d;
      stb_q <= stb_d;
      ck_q  <= ck_d;
      err_q <= err_d;
    end
  end

  pll_div_field #(.W(STC_W), .RST(STC_RST)) u_stc (
    .clk (clk), .rst_n (rst_s), .wr_acc (wr_acc), .allow (fld_allow[0]),
    .wr_val (wr_stc), .commit_go (commit_go), .commit_val (commit_stc), .viol (viol[0])
  );

  pll_div_field #(.W(IFC_W), .RST(IFC_RST)) u_ifc (
    .clk (clk), .rst_n (rst_s), .wr_acc (wr_acc), .allow (fld_allow[1]),
    .wr_val (wr_ifc), .commit_go (commit_go), .commit_val (commit_ifc), .viol (viol[1])
  );

  pll_div_field #(.W(PFC_W), .RST(PFC_RST)) u_pfc (
    .clk (clk), .rst_n (rst_s), .wr_acc (wr_acc), .allow (fld_allow[2]),
    .wr_val (wr_pfc), .commit_go (commit_go), .commit_val (commit_pfc), .viol (viol[2])
  );

  assign pwr_state  = state_q;
  assign ckout_en   = ck_q;
  assign commit_stb = stb_q;
  assign field_err  = err_q;
  assign stby_ok    = !((clk_mode == MODE_LOCK_A) || (clk_mode == MODE_LOCK_B))
                      || (state_q == PWR_OFF);

  // R6
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(busy) |-> commit_stb);

  // R6
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(busy) |-> (state_q == PWR_ON));

  // R9
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (wr_en && busy) |=> $stable(state_q) && $stable(ck_q));

  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_s)
    err_q |=> err_q);

endmodule

// File: tb/pll_pwr_ctrl_bench.sv
module pll_pwr_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] clk_mode;
  logic       wr_en, wr_pll_en, wr_pll_stby, wr_ckout_en;
  logic [2:0] wr_stc, wr_ifc, wr_pfc;
  logic [7:0] wr_settle_start;
  logic [1:0] pwr_state;
  logic       ckout_en, stby_ok, busy, commit_stb, field_err;
  logic [2:0] commit_stc, commit_ifc, commit_pfc;

  always #10 clk = ~clk;

  pll_pwr_ctrl u_pll_pwr_ctrl (
    .clk (clk), .rst_n (rst_n), .clk_mode (clk_mode),
    .wr_en (wr_en), .wr_pll_en (wr_pll_en), .wr_pll_stby (wr_pll_stby),
    .wr_stc (wr_stc), .wr_ifc (wr_ifc), .wr_pfc (wr_pfc),
    .wr_ckout_en (wr_ckout_en), .wr_settle_start (wr_settle_start),
    .pwr_state (pwr_state), .ckout_en (ckout_en), .stby_ok (stby_ok),
    .busy (busy), .commit_stb (commit_stb), .commit_stc (commit_stc),
    .commit_ifc (commit_ifc), .commit_pfc (commit_pfc), .field_err (field_err)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // model of the block, kept from the requirements
  int       m_st;
  logic [2:0] m_stc, m_ifc, m_pfc;
  logic       m_ck, m_err;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int f_target(input int st, input bit en, input bit sb);
    if (en) return (st == 0 && !sb) ? 0 : 2;
    return sb ? 1 : 0;
  endfunction

  function automatic logic [2:0] f_allow(input int st, input int tg);
    if (st == tg) return 3'b111;
    if (st != 2 && tg != 2) return 3'b001;
    if (st == 0 || tg == 0) return 3'b111;
    return 3'b110;
  endfunction

  function automatic int f_stby_ok(input logic [2:0] mode, input int st);
    return (((mode == 3'd3) || (mode == 3'd4)) && st != 0) ? 0 : 1;
  endfunction

  task automatic check_commit(input string req);
    chk(req, "commit_stb", int'(commit_stb), 1);
    chk(req, "commit_stc", int'(commit_stc), int'(m_stc));
    chk(req, "commit_ifc", int'(commit_ifc), int'(m_ifc));
    chk(req, "commit_pfc", int'(commit_pfc), int'(m_pfc));
    @(negedge clk);
    chk(req, "strobe one cycle", int'(commit_stb), 0);
  endtask

  task automatic do_write(input bit en, input bit sb, input logic [2:0] s, input logic [2:0] i,
                          input logic [2:0] p, input bit ck, input logic [7:0] sv,
                          input logic [2:0] mode, input bit rej);
    int tg;
    int n;
    logic [2:0] al;
    bit start;
    @(negedge clk);
    wr_pll_en = en; wr_pll_stby = sb; wr_stc = s; wr_ifc = i; wr_pfc = p;
    wr_ckout_en = ck; wr_settle_start = sv; clk_mode = mode; wr_en = 1'b1;
    tg    = f_target(m_st, en, sb);
    al    = f_allow(m_st, tg);
    start = (tg == 2) && (m_st != 2);
    if (al[0]) m_stc = s; else if (s != m_stc) m_err = 1'b1;
    if (al[1]) m_ifc = i; else if (i != m_ifc) m_err = 1'b1;
    if (al[2]) m_pfc = p; else if (p != m_pfc) m_err = 1'b1;
    m_ck = ck;
    m_st = tg;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R2", "pwr_state", int'(pwr_state), m_st);
    chk("R8", "ckout_en", int'(ckout_en), int'(m_ck));
    chk("R5", "field_err", int'(field_err), int'(m_err));
    chk("R6", "busy after write", int'(busy), int'(start));
    chk("R10", "stby_ok", int'(stby_ok), f_stby_ok(mode, m_st));
    if (start) begin
      n = 0;
      while (busy === 1'b1) begin
        n++;
        if (rej && n == 1) begin
          wr_en = 1'b1; wr_pll_en = 1'b0; wr_pll_stby = 1'b0;
          wr_ckout_en = ~m_ck; wr_stc = ~m_stc; wr_ifc = ~m_ifc; wr_pfc = ~m_pfc;
        end
        @(negedge clk);
        wr_en = 1'b0;
        if (rej && n == 1) begin
          chk("R9", "state kept while busy", int'(pwr_state), m_st);
          chk("R9", "ckout kept while busy", int'(ckout_en), int'(m_ck));
        end
      end
      chk("R6", "busy length", n, 256 - int'(sv));
      check_commit("R6");
    end else begin
      chk("R7", "no strobe yet", int'(commit_stb), 0);
      @(negedge clk);
      check_commit("R7");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; clk_mode = 3'd0; wr_en = 1'b0; wr_pll_en = 1'b0; wr_pll_stby = 1'b0;
    wr_stc = '0; wr_ifc = '0; wr_pfc = '0; wr_ckout_en = 1'b1; wr_settle_start = '0;
    m_st = 0; m_stc = 3'd0; m_ifc = 3'd1; m_pfc = 3'd2; m_ck = 1'b1; m_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1", "pwr_state", int'(pwr_state), 0);
    chk("R1", "ckout_en", int'(ckout_en), 1);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "commit_stb", int'(commit_stb), 0);
    chk("R1", "field_err", int'(field_err), 0);
    chk("R1", "commit_stc", int'(commit_stc), 0);
    chk("R1", "commit_ifc", int'(commit_ifc), 1);
    chk("R1", "commit_pfc", int'(commit_pfc), 2);

    // R2 off -> standby, bus field allowed
    do_write(1'b0, 1'b1, 3'd5, 3'd1, 3'd2, 1'b1, 8'd0, 3'd3, 1'b0);
    // R4 R5 standby -> off with a blocked core field change
    do_write(1'b0, 1'b0, 3'd2, 3'd6, 3'd2, 1'b1, 8'd0, 3'd3, 1'b0);
    chk("R4", "core field kept", int'(commit_ifc), 1);
    // R3 R8 off -> on directly, clock pin off at once
    do_write(1'b1, 1'b1, 3'd3, 3'd4, 3'd7, 1'b0, 8'd250, 3'd4, 1'b0);
    // R4 on -> standby, bus field blocked
    do_write(1'b0, 1'b1, 3'd7, 3'd5, 3'd6, 1'b0, 8'd0, 3'd0, 1'b0);
    chk("R4", "bus field kept", int'(commit_stc), 3);
    // R6 R9 standby -> on, full window, refused write inside it
    do_write(1'b1, 1'b1, 3'd3, 3'd2, 3'd1, 1'b1, 8'd0, 3'd4, 1'b1);
    // R3 on -> off directly
    do_write(1'b0, 1'b0, 3'd6, 3'd0, 3'd3, 1'b1, 8'd0, 3'd3, 1'b0);
    // R3 off with run only stays off
    do_write(1'b1, 1'b0, 3'd1, 3'd1, 3'd1, 1'b1, 8'd255, 3'd3, 1'b0);

    for (int k = 0; k < 80; k++) begin
      do_write(1'($urandom), 1'($urandom), 3'($urandom), 3'($urandom), 3'($urandom),
               1'($urandom), 8'(240 + ($urandom % 16)), 3'($urandom % 6),
               1'(($urandom % 4) == 0));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule